// File: doc/BRIEF.md
# Scroll and VRAM Address Latch

This block holds the processor-facing register state of a tile-based video engine's address path. The CPU builds a 15-bit working word, which carries scroll position and a video memory address, by writing single bytes to two ports. The scroll port fills the coarse column, coarse row and fine row fields. The address port fills the upper and lower halves of a memory address. A single phase flag, shared by both ports, decides whether a write counts as the first or the second of a pair.

A second write to the address port completes the pair, and on that write the working word is copied into the live address register. The low 14 bits of the live address are driven to the video memory bus. The first scroll write also saves the three low data bits as a fine horizontal scroll value. A read of the status register returns the phase flag to "first", so software can resynchronise a write pair. Address stepping during rendering is handled elsewhere.

Top module: `scroll_addr_latch`

## Requirements
- R1: After reset, the working word, the live address, the memory bus address and fine X are all zero, and the next write is a first write.
- R2: A first write to the scroll port (`wr_port`=0) loads working bits 4:0 from data bits 7:3 and fine X from data bits 2:0. All other working bits are left unchanged.
- R3: A second write to the scroll port loads working bits 9:5 from data bits 7:3 and working bits 14:12 from data bits 2:0. Working bits 11:10 and 4:0 and fine X are left unchanged.
- R4: A first write to the address port (`wr_port`=1) loads working bits 13:8 from data bits 5:0 and clears working bit 14. Working bits 7:0 are left unchanged.
- R5: A second write to the address port loads working bits 7:0 from the data byte. On the same edge, the live address takes the complete updated working word.
- R6: The live address changes only on a second write to the address port.
- R7: One phase flag serves both ports and flips after every write to either port. A scroll write followed by an address write therefore makes the address write a second write.
- R8: A status read clears the phase flag. A write in the same cycle as the status read uses the phase that was current before the read, and the write after it is a first write.
- R9: The memory bus address always equals bits 13:0 of the live address.
- R10: In a cycle with no write strobe, the working word and fine X keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_port | input | 1 | Port select: 0 scroll, 1 address |
| wr_data | input | 8 | Written byte |
| stat_rd | input | 1 | Status register read event, clears the phase flag |
| tmp_word | output | 15 | Working scroll/address word |
| live_addr | output | 15 | Live video memory address |
| vram_addr | output | 14 | Address driven to the video memory bus |
| fine_x | output | 3 | Fine horizontal scroll |

## Verification
The bench runs a full scroll pair followed by a full address pair, using data bytes with mixed bit patterns. This shows whether each field reaches its own bit slice and whether the masks keep the neighbouring fields intact. A scroll write followed directly by an address write shows whether the two ports share one phase flag or each keeps its own. A status read placed between the two halves of an address pair, and a status read in the same cycle as a write, separate clear-then-write ordering from write-then-clear ordering. Idle cycles and writes of 0xFF to the address port show whether bit 14 is forced low and whether the live address changes only when an address pair completes.

// File: rtl/scroll_addr_latch.sv
module scroll_addr_latch #(
  parameter int AW     = 15,
  parameter int BUS_W  = 14,
  parameter int FX_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_port,
  input  logic [7:0]       wr_data,
  input  logic             stat_rd,
  output logic [AW-1:0]    tmp_word,
  output logic [AW-1:0]    live_addr,
  output logic [BUS_W-1:0] vram_addr,
  output logic [FX_W-1:0]  fine_x
);

  logic          phase;
  logic [AW-1:0] tmp_nxt;

  wire scr_lo = wr_en && !wr_port && !phase;
  wire scr_hi = wr_en && !wr_port &&  phase;
  wire adr_lo = wr_en &&  wr_port && !phase;
  wire adr_hi = wr_en &&  wr_port &&  phase;

  always_comb begin
    tmp_nxt = tmp_word;
    if (scr_lo) tmp_nxt[4:0] = wr_data[7:3];
    if (scr_hi) begin
      tmp_nxt[9:5]   = wr_data[7:3];
      tmp_nxt[14:12] = wr_data[2:0];
    end
    if (adr_lo) begin
      tmp_nxt[14]   = 1'b0;
      tmp_nxt[13:8] = wr_data[5:0];
    end
    if (adr_hi) tmp_nxt[7:0] = wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmp_word  <= '0;
      live_addr <= '0;
      fine_x    <= '0;
      phase     <= 1'b0;
    end else begin
      tmp_word <= tmp_nxt;
      if (adr_hi) live_addr <= tmp_nxt;
      if (scr_lo) fine_x <= wr_data[FX_W-1:0];
      if (stat_rd)    phase <= 1'b0;
      else if (wr_en) phase <= !phase;
    end
  end

  assign vram_addr = live_addr[BUS_W-1:0];

endmodule

module scroll_addr_latch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wr_port,
  input logic [7:0]  wr_data,
  input logic        stat_rd,
  input logic        phase,
  input logic [14:0] tmp_word,
  input logic [14:0] live_addr,
  input logic [2:0]  fine_x
);

  assert_scroll_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_port && !phase) |=> (tmp_word[4:0] == $past(wr_data[7:3]) && fine_x == $past(wr_data[2:0])));

  assert_scroll_second_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_port && phase) |=> (tmp_word[11:10] == $past(tmp_word[11:10]) && $stable(fine_x)));

  assert_addr_first_bit14_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_port && !phase) |=> (tmp_word[14] == 1'b0 && tmp_word[7:0] == $past(tmp_word[7:0])));

  assert_copy_on_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_port && phase) |=> (live_addr == tmp_word));

  assert_live_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_port && phase) |=> $stable(live_addr));

  assert_phase_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !stat_rd) |=> (phase != $past(phase)));

  assert_status_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !phase);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(tmp_word) && $stable(fine_x)));

endmodule

bind scroll_addr_latch scroll_addr_latch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data),
  .stat_rd(stat_rd), .phase(phase), .tmp_word(tmp_word), .live_addr(live_addr),
  .fine_x(fine_x)
);

// File: tb/scroll_addr_latch_test.sv
module scroll_addr_latch_test;

  typedef struct {
    logic [14:0] tmp;
    logic [14:0] live;
    logic [2:0]  fx;
    string       tag;
  } exp_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic        wr_port = 0;
  logic [7:0]  wr_data = 0;
  logic        stat_rd = 0;
  logic [14:0] tmp_word, live_addr;
  logic [13:0] vram_addr;
  logic [2:0]  fine_x;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  exp_t q[$];

  logic [14:0] m_tmp = 0, m_live = 0;
  logic [2:0]  m_fx = 0;
  logic        m_ph = 0;

  always #5 clk = ~clk;

  scroll_addr_latch uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data),
    .stat_rd(stat_rd), .tmp_word(tmp_word), .live_addr(live_addr),
    .vram_addr(vram_addr), .fine_x(fine_x)
  );

  task automatic push(input string tag);
    exp_t e;
    e.tmp = m_tmp; e.live = m_live; e.fx = m_fx; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic op(input bit en, input bit port, input logic [7:0] d, input bit rd, input string tag);
    @(negedge clk);
    wr_en = en; wr_port = port; wr_data = d; stat_rd = rd;
    if (en) begin
      if (!port && !m_ph) begin m_tmp[4:0] = d[7:3]; m_fx = d[2:0]; end
      if (!port &&  m_ph) begin m_tmp[9:5] = d[7:3]; m_tmp[14:12] = d[2:0]; end
      if ( port && !m_ph) begin m_tmp[14] = 1'b0; m_tmp[13:8] = d[5:0]; end
      if ( port &&  m_ph) begin m_tmp[7:0] = d; m_live = m_tmp; end
    end
    if (rd) m_ph = 1'b0;
    else if (en) m_ph = !m_ph;
    @(posedge clk);
    #1;
    wr_en = 0; stat_rd = 0;
    push(tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (tmp_word !== e.tmp || live_addr !== e.live || fine_x !== e.fx ||
            vram_addr !== e.live[13:0]) begin
          errors++;
          $display("FAIL %s: tmp=%h live=%h vram=%h fx=%0d expected tmp=%h live=%h vram=%h fx=%0d",
                   e.tag, tmp_word, live_addr, vram_addr, fine_x,
                   e.tmp, e.live, e.live[13:0], e.fx);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    push("R1 reset state");
    op(1, 0, 8'hAD, 0, "R2 scroll first");
    op(1, 0, 8'h5E, 0, "R3 scroll second");
    op(1, 1, 8'hFF, 0, "R4 addr first forces bit14 low");
    op(1, 1, 8'h12, 0, "R5 addr second copies to live, R9 bus");
    op(0, 0, 8'hFF, 0, "R10 idle no change");
    op(1, 0, 8'h3B, 0, "R2 scroll first keeps upper bits");
    op(1, 0, 8'hC7, 0, "R3 scroll second keeps bits 11:10");
    op(1, 1, 8'h21, 0, "R4 addr first");
    op(0, 0, 8'h00, 1, "R8 status read alone");
    op(1, 1, 8'h05, 0, "R8 write after status read is first, R6 live held");
    op(1, 1, 8'h80, 0, "R5 addr second after resync");
    op(1, 0, 8'h90, 0, "R7 scroll write as first");
    op(1, 1, 8'h44, 0, "R7 addr write becomes second, R6 live copy");
    op(1, 1, 8'h2A, 1, "R8 write with concurrent status read");
    op(1, 1, 8'h77, 0, "R8 next write treated as first");
    op(1, 1, 8'hE1, 0, "R5 addr second, R9 bus");
    op(1, 0, 8'hFF, 0, "R2 scroll first all ones");
    op(1, 0, 8'hFF, 0, "R3 scroll second all ones, R6 live held");
    op(1, 1, 8'hC0, 0, "R4 addr first with high bits set");
    op(0, 1, 8'h55, 0, "R10 idle with port select high");
    repeat (2) @(negedge clk);
    rst_n = 0;
    m_tmp = 0; m_live = 0; m_fx = 0; m_ph = 0;
    @(posedge clk); #1;
    rst_n = 1;
    push("R1 reset mid-run");
    op(1, 1, 8'h0F, 0, "R1 first write after reset is first");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule